// File: doc/BRIEF.md
# Dual-Channel Interrupt Gate Registers

This block is the small register slave on an expansion card that serves two IDE channels. The drive interrupt request of each channel enters through a two-flop synchronizer and is then captured into a per-channel status bit. Each channel also has a gate register, which turns the channel's interrupt on or off. Any write to the gate offset opens the gate. A read of that same offset closes it. The data bus carries no enable bits. The card gives the host a single combined interrupt line. That line rises only for a channel whose gate is open and whose status bit is set, so a channel whose request line floats cannot disturb the host while its gate is closed.

A card-wide control byte routes the DMA request and acknowledge pair to one of the two channels and opens an extended address window. Writing zero to this byte closes the window and returns the card to its default identification-read state. All accesses are one byte wide, and the decode compares the full address. Read data appears one cycle after the read strobe.

Top module: `dual_chan_irq_gate`

## Requirements
- R1: After reset, both gates are closed, the control byte is 0, `cardIrq`, `dmaChanSel` and `extWinEn` are 0, and `busRdData` is 0.
- R2: A write of any data value to a channel's gate offset (channel 0 at 0x2200, channel 1 at 0x3200) opens that channel's gate from the next cycle on.
- R3: A read of a channel's gate offset closes that channel's gate from the next cycle on. The read returns the gate state before the read in bit 0 and zeros in bits 7:1.
- R4: A read of a channel's status offset (channel 0 at 0x2290, channel 1 at 0x3290) returns the synchronized request level in bit 0 and zeros in bits 7:1. A change on `driveIrqIn` shows up in the status bit after three rising clock edges.
- R5: Status reads have no side effect. The gate states and `cardIrq` are the same after a status read as they were before it.
- R6: `cardIrq` is the OR, over both channels, of (gate open AND status bit set). A channel whose gate is closed never raises `cardIrq`, whatever its request level.
- R7: A write to the control offset 0x0000 stores the byte. Bit 0 drives `dmaChanSel` (0 routes the DMA handshake to channel 0, 1 routes it to channel 1) and bit 5 drives `extWinEn`. A read of 0x0000 returns the stored byte.
- R8: Writing 0 to the control offset clears both `dmaChanSel` and `extWinEn` on the next cycle.
- R9: A read of any unmapped address returns 0. A write to any unmapped address changes no gate and no control bit.
- R10: `busRdData` holds the read result for exactly the cycle after the read strobe and is 0 in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busAddr | input | 14 | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid the cycle after `busRdEn` |
| driveIrqIn | input | 2 | Raw drive interrupt request per channel, asynchronous |
| cardIrq | output | 1 | Combined interrupt to the host |
| dmaChanSel | output | 1 | DMA handshake routing, 0 for channel 0 and 1 for channel 1 |
| extWinEn | output | 1 | Extended address window enable |

## Verification
The assertions assume that the host never raises `busWrEn` and `busRdEn` in the same cycle. They also assume that each strobe is a single-cycle pulse. The properties on gate changes and on the read-data delay are written against that handshake, and with both strobes high at once the write would take priority. The bench drives every access from a task that raises exactly one strobe for one cycle and drops it before the next access. The bench changes the request lines only between accesses, and it waits out the three-edge capture latency before it reads anything that depends on them.

// File: rtl/irqgate_pkg.sv
package irqgate_pkg;

  localparam int NUM_CH = 2;

  // One-cycle strobes from the address decoder to the datapath
  typedef struct packed {
    logic [NUM_CH-1:0] setEn;
    logic [NUM_CH-1:0] clrEn;
    logic [NUM_CH-1:0] rdGate;
    logic [NUM_CH-1:0] rdStat;
    logic              ctrlWr;
    logic              rdCtrl;
  } strobes_t;

endpackage

// File: rtl/irqgate_decode.sv
module irqgate_decode
  import irqgate_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int CTRL_OFS   = 'h0000,
  parameter int GATE_BASE  = 'h2200,
  parameter int CH_STRIDE  = 'h1000,
  parameter int STAT_DELTA = 'h0090
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobes_t          strb
);

  logic rdOnly;
  assign rdOnly = busRdEn && !busWrEn;

  always_comb begin
    strb        = '0;
    strb.ctrlWr = busWrEn && (busAddr == ADDR_W'(CTRL_OFS));
    strb.rdCtrl = rdOnly && (busAddr == ADDR_W'(CTRL_OFS));
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (busAddr == ADDR_W'(GATE_BASE + ch * CH_STRIDE)) begin
        strb.setEn[ch]  = busWrEn;
        strb.clrEn[ch]  = rdOnly;
        strb.rdGate[ch] = rdOnly;
      end
      if (busAddr == ADDR_W'(GATE_BASE + ch * CH_STRIDE + STAT_DELTA)) begin
        strb.rdStat[ch] = rdOnly;
      end
    end
  end

endmodule

// File: rtl/irqgate_datapath.sv
module irqgate_datapath
  import irqgate_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_BIT     = 5,
  parameter int DMA_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [NUM_CH-1:0] driveIrqIn,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] chanEn,
  output logic [NUM_CH-1:0] chanStat,
  output logic              cardIrq,
  output logic              dmaChanSel,
  output logic              extWinEn
);

  logic [DATA_W-1:0] ctrlQ;
  logic [DATA_W-1:0] rdNext;

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          syncQ        <= '0;
          chanStat[ch] <= 1'b0;
          chanEn[ch]   <= 1'b0;
        end else begin
          syncQ        <= {syncQ[SYNC_STAGES-2:0], driveIrqIn[ch]};
          chanStat[ch] <= syncQ[SYNC_STAGES-1];
          if (strb.setEn[ch])      chanEn[ch] <= 1'b1;
          else if (strb.clrEn[ch]) chanEn[ch] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrlQ <= '0;
    else if (strb.ctrlWr) ctrlQ <= busWrData;
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdCtrl) rdNext = ctrlQ;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strb.rdGate[c]) rdNext = DATA_W'(chanEn[c]);
      if (strb.rdStat[c]) rdNext = DATA_W'(chanStat[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busRdData <= '0;
    else        busRdData <= rdNext;
  end

  assign cardIrq    = |(chanEn & chanStat);
  assign dmaChanSel = ctrlQ[DMA_BIT];
  assign extWinEn   = ctrlQ[WIN_BIT];

endmodule

// File: rtl/dual_chan_irq_gate.sv
module dual_chan_irq_gate
  import irqgate_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_OFS    = 'h0000,
  parameter int GATE_BASE   = 'h2200,
  parameter int CH_STRIDE   = 'h1000,
  parameter int STAT_DELTA  = 'h0090
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [1:0]        driveIrqIn,
  output logic              cardIrq,
  output logic              dmaChanSel,
  output logic              extWinEn
);

  strobes_t          strb;
  logic [NUM_CH-1:0] chanEn;
  logic [NUM_CH-1:0] chanStat;

  irqgate_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .GATE_BASE(GATE_BASE),
    .CH_STRIDE(CH_STRIDE), .STAT_DELTA(STAT_DELTA)
  ) u_decode (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .strb(strb)
  );

  irqgate_datapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busWrData(busWrData),
    .driveIrqIn(driveIrqIn), .busRdData(busRdData), .chanEn(chanEn),
    .chanStat(chanStat), .cardIrq(cardIrq), .dmaChanSel(dmaChanSel),
    .extWinEn(extWinEn)
  );

endmodule

// File: rtl/irqgate_chk.sv
module irqgate_chk #(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int CTRL_OFS   = 'h0000,
  parameter int GATE_BASE  = 'h2200,
  parameter int CH_STRIDE  = 'h1000,
  parameter int STAT_DELTA = 'h0090
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              cardIrq,
  input logic              dmaChanSel,
  input logic              extWinEn,
  input logic [1:0]        chanEn,
  input logic [1:0]        chanStat
);

  localparam logic [ADDR_W-1:0] G0 = ADDR_W'(GATE_BASE);
  localparam logic [ADDR_W-1:0] G1 = ADDR_W'(GATE_BASE + CH_STRIDE);
  localparam logic [ADDR_W-1:0] S0 = ADDR_W'(GATE_BASE + STAT_DELTA);
  localparam logic [ADDR_W-1:0] S1 = ADDR_W'(GATE_BASE + CH_STRIDE + STAT_DELTA);
  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_OFS);

  // R2
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busWrEn && (busAddr == G1) |=> chanEn[1]);

  // R3
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busRdEn && !busWrEn && (busAddr == G0) |=> !chanEn[0]);

  // R5
  stat_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busRdEn && !busWrEn && ((busAddr == S0) || (busAddr == S1)) |=> $stable(chanEn));

  // R6
  closed_gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chanEn == 2'b00) |-> !cardIrq);

  // R8
  ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busWrEn && (busAddr == CA) && (busWrData == '0) |=> !dmaChanSel && !extWinEn);

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busRdEn |=> (busRdData == '0));

  // R4
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busRdEn && !busWrEn && (busAddr == S0) |=> (busRdData[DATA_W-1:1] == '0));

endmodule

bind dual_chan_irq_gate irqgate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .GATE_BASE(GATE_BASE),
  .CH_STRIDE(CH_STRIDE), .STAT_DELTA(STAT_DELTA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
  .cardIrq(cardIrq), .dmaChanSel(dmaChanSel), .extWinEn(extWinEn),
  .chanEn(chanEn), .chanStat(chanStat)
);

// File: tb/dual_chan_irq_gate_bench.sv
module dual_chan_irq_gate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [1:0]  driveIrqIn = 2'b00;
  logic        cardIrq, dmaChanSel, extWinEn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_chan_irq_gate u_dual_chan_irq_gate (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .driveIrqIn(driveIrqIn), .cardIrq(cardIrq), .dmaChanSel(dmaChanSel),
    .extWinEn(extWinEn)
  );

  function automatic logic [13:0] gateAddr(int ch); return 14'h2200 + 14'(ch * 'h1000); endfunction
  function automatic logic [13:0] statAddr(int ch); return 14'h2290 + 14'(ch * 'h1000); endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [13:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [13:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic setIrq(logic [1:0] v);
    @(negedge clk);
    driveIrqIn = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  logic [1:0] enModel = 2'b00;
  logic [7:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cardIrq", 8'(cardIrq), 8'h0);
    chk("R1 dmaChanSel", 8'(dmaChanSel), 8'h0);
    chk("R1 extWinEn", 8'(extWinEn), 8'h0);
    chk("R1 busRdData", busRdData, 8'h0);
    busRead(14'h0000, rd); chk("R1 ctrl readback", rd, 8'h0);
    setIrq(2'b11);
    chk("R1 gates closed", 8'(cardIrq), 8'h0);

    // Sweep gate patterns against request patterns
    for (int en = 0; en < 4; en++) begin
      for (int irq = 0; irq < 4; irq++) begin
        for (int ch = 0; ch < 2; ch++) begin
          if (en[ch]) begin
            busWrite(gateAddr(ch), 8'(en * 37 + irq * 11 + ch)); // R2 any data
            enModel[ch] = 1'b1;
          end else begin
            busRead(gateAddr(ch), rd);
            chk("R3 gate read old state", rd, 8'(enModel[ch]));
            enModel[ch] = 1'b0;
          end
        end
        setIrq(2'(irq));
        chk("R6 cardIrq", 8'(cardIrq), 8'(|(enModel & 2'(irq))));
        for (int ch = 0; ch < 2; ch++) begin
          busRead(statAddr(ch), rd);
          chk("R4 status", rd, 8'(irq[ch]));
          @(negedge clk);
          chk("R10 idle data", busRdData, 8'h0);
        end
        chk("R5 cardIrq after status reads", 8'(cardIrq), 8'(|(enModel & 2'(irq))));
        for (int ch = 0; ch < 2; ch++) begin
          if (enModel[ch]) begin
            busRead(gateAddr(ch), rd);
            chk("R3 open gate reads 1", rd, 8'h1);
            enModel[ch] = 1'b0;
            busWrite(gateAddr(ch), 8'h00); // R2 zero data still opens
            enModel[ch] = 1'b1;
          end
        end
        chk("R2 reopened", 8'(cardIrq), 8'(|(enModel & 2'(irq))));
      end
    end

    // R4 latency: change not seen after two edges, seen after three
    busRead(gateAddr(0), rd); busRead(gateAddr(1), rd); enModel = 2'b00;
    setIrq(2'b00);
    busWrite(gateAddr(0), 8'h5A); enModel[0] = 1'b1;
    @(negedge clk); driveIrqIn = 2'b01;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R4 not yet after two edges", 8'(cardIrq), 8'h0);
    @(posedge clk); @(negedge clk);
    chk("R4 visible after three edges", 8'(cardIrq), 8'h1);

    // R9 unmapped addresses
    busRead(gateAddr(0), rd); enModel = 2'b00;
    setIrq(2'b11);
    begin
      logic [13:0] holes [4] = '{14'h0001, 14'h2201, 14'h2291, 14'h3FFF};
      foreach (holes[i]) begin
        busWrite(holes[i], 8'hFF);
        busRead(holes[i], rd);
        chk("R9 unmapped read", rd, 8'h0);
        chk("R9 unmapped write no gate", 8'(cardIrq), 8'h0);
        chk("R9 unmapped write no ctrl", 8'({extWinEn, dmaChanSel}), 8'h0);
      end
    end

    // R7 full control sweep, R8 clear
    for (int v = 0; v < 256; v++) begin
      busWrite(14'h0000, 8'(v));
      chk("R7 dmaChanSel", 8'(dmaChanSel), 8'(v & 1));
      chk("R7 extWinEn", 8'(extWinEn), 8'((v >> 5) & 1));
      busRead(14'h0000, rd);
      chk("R7 ctrl readback", rd, 8'(v));
      if (v[0] || v[5]) begin
        busWrite(14'h0000, 8'h00);
        chk("R8 cleared", 8'({extWinEn, dmaChanSel}), 8'h0);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule